// File: doc/BRIEF.md
# Multi-Window Moving Sum Engine

This block keeps a set of running window sums for each of several independent sample channels. Samples arrive one at a time, each tagged with its channel. Every accepted sample is stored in that channel's circular history, and each window sum of the channel is updated by one add-new/subtract-leaving step. The whole window is never re-summed. One time-shared datapath serves all windows of all channels, one window per clock cycle.

Each channel has two families of windows. The short windows cover raw samples. The long windows cover block averages: each run of eight consecutive samples on a channel is reduced to the floor of its mean, and only that mean is stored. This cuts the history storage of the long windows by a factor of eight. A readback port returns any window sum of any channel at any time, combinationally. The input side is a valid/ready pair. While an update is in progress the block is busy and refuses new samples.

With default parameters there are 16 channels of 8-bit unsigned samples and 10 windows per channel. A sample is processed in 5 cycles, or in 10 cycles when it closes a group of eight. This is far inside a per-channel sample period of tens of microseconds.

Top module: `mws_engine`

## Requirements
- R1: After reset every window sum reads 0, `in_ready` is 1 and `busy` is 0.
- R2: Window index k in 0..4 of a channel holds the sum of that channel's last 2^(k+1) accepted samples, so its lengths are 2, 4, 8, 16 and 32.
- R3: Window index k in 5..9 holds the sum of the last 2^(k-4) group averages of that channel. A group average is floor(sum of 8 consecutive accepted samples of the channel / 8).
- R4: Before a window has been filled once, samples that have not yet arrived count as zero, so the window returns the sum of everything received so far.
- R5: Channels are independent. Samples for one channel never change the sums read for another.
- R6: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `busy` is then high for exactly 5 cycles, or for 10 cycles when the sample is the eighth of its group. `in_ready` is the inverse of `busy`.
- R7: A sample offered while `busy` is 1 is refused and has no effect on any sum.
- R8: A stream of all-255 samples yields exactly 255·2^(k+1) on short windows and 255·2^(k-4) on long windows, with no wrap of the accumulators.
- R9: A readback with a window index of 10 or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_ch | input | 4 | Channel of the offered sample |
| in_data | input | 8 | Unsigned sample value |
| busy | output | 1 | Window updates for an accepted sample are in progress |
| rd_ch | input | 4 | Channel selected for readback |
| rd_win | input | 4 | Window selected for readback (0..9) |
| rd_sum | output | 14 | Sum of the selected window, never negative |

## Verification
A wrong history pointer or fill count shows up on a readback as a sum that is off by exactly one leaving sample. This happens from the first update after the window reaches its length, and for a fill error already during warm-up. A corrupted accumulator stays wrong from that point on, because the sum is only ever adjusted incrementally and never rebuilt. A group counter or averaging error touches only the long windows, and appears one group, that is eight samples, after the fault. The bench therefore compares every window of a channel against sums recomputed from the full sample history. It does so after warm-up, after wrap-around and after group boundaries.

// File: rtl/mws_pkg.sv
package mws_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHORT = 2'd1,
    PH_LONG  = 2'd2
  } phase_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mws_hist.sv
// Per-channel circular history with fill tracking.
module mws_hist #(
  parameter int NUM_CH  = 16,
  parameter int DW      = 8,
  parameter int DEPTH_W = 6,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DEPTH  = 1 << DEPTH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [DW-1:0]      wr_data,
  input  logic               adv_en,
  input  logic [CH_W-1:0]    ch,
  input  logic [DEPTH_W-1:0] rd_back,
  output logic [DW-1:0]      rd_data,
  output logic               rd_live
);
  logic [DW-1:0]      mem_q  [NUM_CH*DEPTH];
  logic [DEPTH_W-1:0] ptr_q  [NUM_CH];
  logic [DEPTH_W-1:0] ptr_d  [NUM_CH];
  logic [DEPTH_W:0]   fill_q [NUM_CH];
  logic [DEPTH_W:0]   fill_d [NUM_CH];
  logic [DEPTH_W-1:0] rd_addr;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[int'(wr_ch)*DEPTH + int'(ptr_q[wr_ch])] <= wr_data;
  end

  always_comb begin
    ptr_d  = ptr_q;
    fill_d = fill_q;
    if (adv_en) begin
      ptr_d[ch] = ptr_q[ch] + DEPTH_W'(1);
      if (fill_q[ch] != (DEPTH_W+1)'(DEPTH)) fill_d[ch] = fill_q[ch] + (DEPTH_W+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        ptr_q[i]  <= '0;
        fill_q[i] <= '0;
      end
    end else if (adv_en) begin
      ptr_q  <= ptr_d;
      fill_q <= fill_d;
    end
  end

  assign rd_addr = ptr_q[ch] - rd_back;
  assign rd_live = fill_q[ch] >= {1'b0, rd_back};
  assign rd_data = mem_q[int'(ch)*DEPTH + int'(rd_addr)];

  AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> fill_q[$past(ch)] != '0); // R4
endmodule

// File: rtl/mws_grp.sv
// Per-channel group-of-2^GRP_LOG2 averager feeding the long windows.
module mws_grp #(
  parameter int NUM_CH   = 16,
  parameter int DW       = 8,
  parameter int GRP_LOG2 = 3,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SUM_W   = DW + GRP_LOG2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [CH_W-1:0] ch,
  input  logic [DW-1:0]   data,
  output logic            last,
  output logic [DW-1:0]   avg
);
  logic [SUM_W-1:0]    sum_q [NUM_CH];
  logic [SUM_W-1:0]    sum_d [NUM_CH];
  logic [GRP_LOG2-1:0] cnt_q [NUM_CH];
  logic [GRP_LOG2-1:0] cnt_d [NUM_CH];
  logic [SUM_W-1:0]    total;

  assign total = sum_q[ch] + SUM_W'(data);
  assign last  = (cnt_q[ch] == '1);
  assign avg   = total[SUM_W-1:GRP_LOG2];

  always_comb begin
    sum_d = sum_q;
    cnt_d = cnt_q;
    if (step) begin
      if (last) begin
        sum_d[ch] = '0;
        cnt_d[ch] = '0;
      end else begin
        sum_d[ch] = total;
        cnt_d[ch] = cnt_q[ch] + GRP_LOG2'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        sum_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else if (step) begin
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/mws_accbank.sv
// Bank of signed window accumulators, one write port, one readback port.
module mws_accbank #(
  parameter int NUM_CH  = 16,
  parameter int NUM_WIN = 10,
  parameter int ACC_W   = 14,
  parameter int MAX_SUM = 8160,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int NACC   = NUM_CH * NUM_WIN,
  localparam int IX_W   = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic [CH_W-1:0]         upd_ch,
  input  logic [WIN_W-1:0]        upd_win,
  input  logic signed [ACC_W-1:0] delta,
  input  logic [CH_W-1:0]         rd_ch,
  input  logic [WIN_W-1:0]        rd_win,
  output logic [ACC_W-1:0]        rd_sum
);
  logic signed [ACC_W-1:0] acc_q [NACC];
  logic signed [ACC_W-1:0] acc_d;
  logic [IX_W-1:0]         upd_ix;

  assign upd_ix = IX_W'(int'(upd_ch) * NUM_WIN + int'(upd_win));
  assign acc_d  = acc_q[upd_ix] + delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NACC; i++) acc_q[i] <= '0;
    end else if (upd_en) begin
      acc_q[upd_ix] <= acc_d;
    end
  end

  always_comb begin
    rd_sum = '0;
    if (int'(rd_win) < NUM_WIN) rd_sum = acc_q[int'(rd_ch) * NUM_WIN + int'(rd_win)];
  end

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (acc_q[$past(upd_ix)] >= 0) && (acc_q[$past(upd_ix)] <= MAX_SUM)); // R8
endmodule

// File: rtl/mws_ctrl.sv
// Sequencer: accept, short-window sweep, optional long-window sweep.
module mws_ctrl
  import mws_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int SMP_W     = 8,
  parameter int NUM_SHORT = 5,
  parameter int NUM_LONG  = 5,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int IDX_W    = $clog2(imax(NUM_SHORT, NUM_LONG)),
  localparam int BCNT_W   = $clog2(NUM_SHORT + NUM_LONG + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CH_W-1:0]  in_ch,
  input  logic [SMP_W-1:0] in_data,
  input  logic             grp_last,
  input  logic [SMP_W-1:0] grp_avg,
  output logic             in_ready,
  output logic             busy,
  output logic [CH_W-1:0]  cur_ch,
  output logic [SMP_W-1:0] cur_data,
  output logic [SMP_W-1:0] avg_val,
  output logic             sel_long,
  output logic [IDX_W-1:0] widx,
  output logic             raw_wr,
  output logic             raw_adv,
  output logic             grp_step,
  output logic             avg_wr,
  output logic             avg_adv
);
  phase_e             ph_q, ph_d;
  logic [IDX_W-1:0]   widx_q, widx_d;
  logic [CH_W-1:0]    ch_q, ch_d;
  logic [SMP_W-1:0]   dat_q, dat_d;
  logic [SMP_W-1:0]   avg_q, avg_d;
  logic [BCNT_W-1:0]  bcnt_q;

  always_comb begin
    ph_d     = ph_q;
    widx_d   = widx_q;
    ch_d     = ch_q;
    dat_d    = dat_q;
    avg_d    = avg_q;
    raw_adv  = 1'b0;
    grp_step = 1'b0;
    avg_wr   = 1'b0;
    avg_adv  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (in_valid) begin
          ph_d   = PH_SHORT;
          widx_d = '0;
          ch_d   = in_ch;
          dat_d  = in_data;
        end
      end
      PH_SHORT: begin
        if (widx_q == IDX_W'(NUM_SHORT - 1)) begin
          raw_adv  = 1'b1;
          grp_step = 1'b1;
          widx_d   = '0;
          if (grp_last) begin
            avg_wr = 1'b1;
            avg_d  = grp_avg;
            ph_d   = PH_LONG;
          end else begin
            ph_d = PH_IDLE;
          end
        end else begin
          widx_d = widx_q + IDX_W'(1);
        end
      end
      PH_LONG: begin
        if (widx_q == IDX_W'(NUM_LONG - 1)) begin
          avg_adv = 1'b1;
          ph_d    = PH_IDLE;
        end else begin
          widx_d = widx_q + IDX_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      widx_q <= '0;
      ch_q   <= '0;
      dat_q  <= '0;
      avg_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      widx_q <= widx_d;
      ch_q   <= ch_d;
      dat_q  <= dat_d;
      avg_q  <= avg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt_q <= '0;
    else if (busy) bcnt_q <= bcnt_q + BCNT_W'(1);
    else           bcnt_q <= '0;
  end

  assign busy     = (ph_q != PH_IDLE);
  assign in_ready = !busy;
  assign raw_wr   = in_valid && in_ready;
  assign cur_ch   = ch_q;
  assign cur_data = dat_q;
  assign avg_val  = avg_q;
  assign sel_long = (ph_q == PH_LONG);
  assign widx     = widx_q;

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid)); // R7
  AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt_q < BCNT_W'(NUM_SHORT + NUM_LONG))); // R6
endmodule

// File: rtl/mws_engine.sv
// Top: multi-window moving sum engine.
module mws_engine
  import mws_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int SMP_W     = 8,
  parameter int NUM_SHORT = 5,
  parameter int NUM_LONG  = 5,
  parameter int GRP_LOG2  = 3,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NUM_WIN  = NUM_SHORT + NUM_LONG,
  localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int MAX_LEN  = 1 << imax(NUM_SHORT, NUM_LONG),
  localparam int MAX_SUM  = MAX_LEN * ((1 << SMP_W) - 1),
  localparam int ACC_W    = $clog2(MAX_SUM + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CH_W-1:0]  in_ch,
  input  logic [SMP_W-1:0] in_data,
  output logic             busy,
  input  logic [CH_W-1:0]  rd_ch,
  input  logic [WIN_W-1:0] rd_win,
  output logic [ACC_W-1:0] rd_sum
);
  localparam int RAW_DW = NUM_SHORT + 1;
  localparam int AVG_DW = NUM_LONG + 1;
  localparam int IDX_W  = $clog2(imax(NUM_SHORT, NUM_LONG));

  logic [CH_W-1:0]  cur_ch;
  logic [SMP_W-1:0] cur_data, avg_val, grp_avg, raw_rd, avg_rd, new_v, old_v;
  logic             sel_long, raw_wr, raw_adv, grp_step, avg_wr, avg_adv;
  logic             grp_last, raw_live, avg_live;
  logic [IDX_W-1:0] widx;
  logic [RAW_DW-1:0] raw_back;
  logic [AVG_DW-1:0] avg_back;
  logic [WIN_W-1:0]  upd_win;
  logic signed [ACC_W-1:0] delta;

  mws_ctrl #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .NUM_SHORT(NUM_SHORT), .NUM_LONG(NUM_LONG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_data(in_data),
    .grp_last(grp_last), .grp_avg(grp_avg), .in_ready(in_ready), .busy(busy),
    .cur_ch(cur_ch), .cur_data(cur_data), .avg_val(avg_val), .sel_long(sel_long),
    .widx(widx), .raw_wr(raw_wr), .raw_adv(raw_adv), .grp_step(grp_step),
    .avg_wr(avg_wr), .avg_adv(avg_adv)
  );

  assign raw_back = RAW_DW'(2) << widx;
  assign avg_back = AVG_DW'(2) << widx;

  mws_hist #(.NUM_CH(NUM_CH), .DW(SMP_W), .DEPTH_W(RAW_DW)) u_raw (
    .clk(clk), .rst_n(rst_n), .wr_en(raw_wr), .wr_ch(in_ch), .wr_data(in_data),
    .adv_en(raw_adv), .ch(cur_ch), .rd_back(raw_back), .rd_data(raw_rd), .rd_live(raw_live)
  );

  mws_grp #(.NUM_CH(NUM_CH), .DW(SMP_W), .GRP_LOG2(GRP_LOG2)) u_grp (
    .clk(clk), .rst_n(rst_n), .step(grp_step), .ch(cur_ch), .data(cur_data),
    .last(grp_last), .avg(grp_avg)
  );

  mws_hist #(.NUM_CH(NUM_CH), .DW(SMP_W), .DEPTH_W(AVG_DW)) u_avg (
    .clk(clk), .rst_n(rst_n), .wr_en(avg_wr), .wr_ch(cur_ch), .wr_data(grp_avg),
    .adv_en(avg_adv), .ch(cur_ch), .rd_back(avg_back), .rd_data(avg_rd), .rd_live(avg_live)
  );

  always_comb begin
    new_v = sel_long ? avg_val : cur_data;
    if (sel_long) old_v = avg_live ? avg_rd : '0;
    else          old_v = raw_live ? raw_rd : '0;
    delta   = $signed(ACC_W'(new_v)) - $signed(ACC_W'(old_v));
    upd_win = sel_long ? (WIN_W'(NUM_SHORT) + WIN_W'(widx)) : WIN_W'(widx);
  end

  mws_accbank #(.NUM_CH(NUM_CH), .NUM_WIN(NUM_WIN), .ACC_W(ACC_W), .MAX_SUM(MAX_SUM)) u_acc (
    .clk(clk), .rst_n(rst_n), .upd_en(busy), .upd_ch(cur_ch), .upd_win(upd_win),
    .delta(delta), .rd_ch(rd_ch), .rd_win(rd_win), .rd_sum(rd_sum)
  );
endmodule

// File: tb/mws_engine_test.sv
module mws_engine_test;
  localparam int NCH = 16;
  localparam int NS  = 5;
  localparam int NW  = 10;

  logic        clk, rst_n, in_valid, in_ready, busy;
  logic [3:0]  in_ch, rd_ch, rd_win;
  logic [7:0]  in_data;
  logic [13:0] rd_sum;

  int checks = 0, errors = 0;
  int raw_h [NCH][1024];
  int raw_n [NCH];
  int avg_h [NCH][256];
  int avg_n [NCH];
  int g_sum [NCH];
  int g_cnt [NCH];
  int seed = 7;

  mws_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ch(in_ch), .in_data(in_data), .busy(busy),
    .rd_ch(rd_ch), .rd_win(rd_win), .rd_sum(rd_sum)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sum(int ch, int w);
    int s = 0;
    if (w < NS) begin
      int len = 2 << w;
      for (int j = (raw_n[ch] > len ? raw_n[ch] - len : 0); j < raw_n[ch]; j++) s += raw_h[ch][j];
    end else begin
      int len = 2 << (w - NS);
      for (int j = (avg_n[ch] > len ? avg_n[ch] - len : 0); j < avg_n[ch]; j++) s += avg_h[ch][j];
    end
    return s;
  endfunction

  function automatic logic [7:0] rnd();
    seed = seed * 1103515245 + 12345;
    return seed[23:16];
  endfunction

  task automatic model_push(int ch, int d);
    raw_h[ch][raw_n[ch]] = d;
    raw_n[ch]++;
    g_sum[ch] += d;
    g_cnt[ch]++;
    if (g_cnt[ch] == 8) begin
      avg_h[ch][avg_n[ch]] = g_sum[ch] / 8;
      avg_n[ch]++;
      g_sum[ch] = 0;
      g_cnt[ch] = 0;
    end
  endtask

  task automatic read_win(int ch, int w, output int v);
    @(negedge clk);
    rd_ch = 4'(ch);
    rd_win = 4'(w);
    #1 v = int'(rd_sum);
  endtask

  task automatic check_all(int ch, string req);
    int v;
    for (int w = 0; w < NW; w++) begin
      read_win(ch, w, v);
      check(req, v, exp_sum(ch, w));
    end
  endtask

  task automatic send(int ch, logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_ch = 4'(ch);
    in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    model_push(ch, int'(d));
    while (!in_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    check("R1 ready", int'(in_ready), 1);
    check("R1 busy", int'(busy), 0);
    read_win(0, 0, v);  check("R1 sum", v, 0);
    read_win(15, 9, v); check("R1 sum", v, 0);
    read_win(7, 4, v);  check("R1 sum", v, 0);
  endtask

  task automatic t_warmup();
    send(3, 8'd10); send(3, 8'd20); send(3, 8'd30); send(3, 8'd40); send(3, 8'd50);
    check_all(3, "R4 warm-up");
  endtask

  task automatic t_refuse();
    @(negedge clk);
    in_valid = 1'b1; in_ch = 4'd3; in_data = 8'd60;
    @(negedge clk);
    model_push(3, 60);
    in_ch = 4'd3; in_data = 8'd200;
    check("R7 ready low while busy", int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R7 no second accept", int'(busy), 0);
    check_all(3, "R7 refused sample ignored");
  endtask

  task automatic t_timing(int ch);
    for (int k = 0; k < 9; k++) begin
      int cnt = 0;
      int exp_c = (g_cnt[ch] == 7) ? 10 : 5;
      @(negedge clk);
      in_valid = 1'b1; in_ch = 4'(ch); in_data = rnd();
      @(negedge clk);
      in_valid = 1'b0;
      model_push(ch, int'(in_data));
      while (busy) begin
        if (in_ready) check("R6 ready inverse of busy", int'(in_ready), 0);
        cnt++;
        @(negedge clk);
      end
      check("R6 busy cycles", cnt, exp_c);
    end
    check_all(ch, "R3 long windows after group");
  endtask

  task automatic t_long(int ch);
    for (int k = 0; k < 300; k++) send(ch, rnd());
    check_all(ch, "R2 R3 wrapped windows");
  endtask

  task automatic t_interleave();
    for (int r = 0; r < 40; r++)
      for (int c = 0; c < NCH; c++)
        if (c != 15) send(c, rnd());
    for (int c = 0; c < NCH; c++)
      if (c != 15) check_all(c, "R5 channel independence");
  endtask

  task automatic t_max();
    int v;
    for (int k = 0; k < 264; k++) send(15, 8'd255);
    for (int w = 0; w < NW; w++) begin
      read_win(15, w, v);
      check("R8 full-scale sum", v, (w < NS) ? 255 * (2 << w) : 255 * (2 << (w - NS)));
    end
  endtask

  task automatic t_oob();
    int v;
    for (int w = 10; w < 16; w++) begin
      read_win(15, w, v);
      check("R9 out-of-range window", v, 0);
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      raw_n[c] = 0; avg_n[c] = 0; g_sum[c] = 0; g_cnt[c] = 0;
    end
    in_valid = 1'b0; in_ch = '0; in_data = '0; rd_ch = '0; rd_win = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_warmup();
    t_refuse();
    t_timing(3);
    t_long(7);
    t_interleave();
    t_max();
    t_oob();
    check_all(7, "R5 channel 7 undisturbed");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule